// File: doc/BRIEF.md
# YCbCr Input Demultiplexer

This block sits at the entry of a video pipeline. It receives pixel data on three parallel sample buses, called the Y, C and S buses, and produces one aligned stream of luma, blue-difference and red-difference samples. Every output pixel carries a single valid strobe. A set of static configuration inputs chooses how the buses are read. In the full-rate format each bus carries one component on every pixel. In the half-rate chroma format one bus carries luma and another carries Cb and Cr in alternation. In the double-data-rate format one bus carries luma and chroma interleaved on both edges of the pixel clock.

The block handles the double-data-rate format with a system clock at twice the pixel rate. An `edge_rise` input tags the samples that belong to the rising edge of the pixel clock, so the whole design uses one clock edge only. In the half-rate formats the chroma phase starts again at each falling edge of the active-low line sync. Each received Cb/Cr pair is then repeated over the two pixels of that pair. Further inputs exchange the Y and S buses and select 8-bit samples, which are carried on the upper lines of each bus.

Top module: `ycc_demux`

## Requirements
- R1: With `cfg_fmt422`=0 and `cfg_ddr`=0, each edge with `in_valid`=1 yields one output pixel after that same edge, with Y from the Y bus, Cb from the C bus and Cr from the S bus.
- R2: With `cfg_swap`=1 the Y and S buses exchange roles in every format before any other decoding is done.
- R3: With `cfg_narrow`=1 bus lines 1:0 are ignored. Each sample becomes lines 9:2 followed by two zero bits, so bits 1:0 of every output are 0.
- R4: With `cfg_fmt422`=1 each input word takes luma from the Y bus and one chroma sample from the C bus. The edge that takes the second word of a pair outputs the first pixel, and the next edge outputs the second pixel. Both pixels carry the same Cb and Cr.
- R5: `cfg_cr_first`=0 makes the first chroma sample of a pair Cb. `cfg_cr_first`=1 makes it Cr.
- R6: An edge where `hsync_n` is 0 after it was 1 on the previous edge restarts the pair phase. A word taken on that edge is the first of a pair, and an incomplete pair is dropped without output.
- R7: With `cfg_ddr`=1 samples come from the Y bus, or from the S bus when swapped. With `cfg_y_on_rise`=0 the sample tagged `edge_rise`=1 is chroma and the next untagged sample is luma; with `cfg_y_on_rise`=1 these roles are reversed. A word completes on the untagged sample and is then paired as in R4 to R6.
- R8: After reset `out_valid` and all output samples are 0. `out_valid` is 1 only on the cycles named in R1, R4 and R7.
- R9: Edges with `in_valid`=0 do not change the outputs or the pair phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (twice the pixel rate in double-data-rate format) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bus contents hold a sample on this edge |
| hsync_n | input | 1 | Active-low line sync; its falling edge restarts the chroma phase |
| edge_rise | input | 1 | Sample belongs to the rising pixel-clock edge (double-data-rate format) |
| y_bus | input | DW | Luma bus |
| c_bus | input | DW | Blue-difference or shared chroma bus |
| s_bus | input | DW | Red-difference or alternate luma bus |
| cfg_fmt422 | input | 1 | Half-rate chroma on the C bus |
| cfg_ddr | input | 1 | Luma and chroma on one bus, both edges |
| cfg_cr_first | input | 1 | First chroma of a pair is Cr |
| cfg_swap | input | 1 | Exchange Y and S buses |
| cfg_narrow | input | 1 | 8-bit samples on upper bus lines |
| cfg_y_on_rise | input | 1 | Luma on the tagged (rising) sample |
| out_valid | output | 1 | One strobe per output pixel |
| out_y | output | DW | Luma output |
| out_cb | output | DW | Cb output |
| out_cr | output | DW | Cr output |

## Verification
The assertions assume that the configuration inputs only change while reset is held. Under this assumption a pixel that waits for its second output cycle is always decoded with the format it entered under, and the low-bit check for 8-bit samples holds for every strobe. The bench therefore applies reset before each new configuration. Within a run it varies only the valid pattern, the bus data, the line-sync timing and, in double-data-rate runs, the edge tag. It chooses line lengths that cut pairs in half, so that the dropped-pair case is reached.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  typedef enum logic [1:0] {
    MODE_444 = 2'd0,
    MODE_422 = 2'd1,
    MODE_DDR = 2'd2
  } ycc_mode_e;

  function automatic ycc_mode_e mode_of(input logic fmt422, input logic ddr);
    if (ddr) return MODE_DDR;
    if (fmt422) return MODE_422;
    return MODE_444;
  endfunction
endpackage

// File: rtl/ycc_lane_sel.sv
module ycc_lane_sel #(
  parameter int DW   = 10,
  parameter int DROP = 2
) (
  input  logic [DW-1:0] y_bus,
  input  logic [DW-1:0] c_bus,
  input  logic [DW-1:0] s_bus,
  input  logic          swap,
  input  logic          narrow,
  output logic [DW-1:0] lane_y,
  output logic [DW-1:0] lane_c,
  output logic [DW-1:0] lane_s
);
  localparam int          NL       = 3;
  localparam logic [DW-1:0] LOW_MASK = DW'((1 << DROP) - 1);

  function automatic logic [DW-1:0] trim(input logic [DW-1:0] v, input logic nar);
    return nar ? (v & ~LOW_MASK) : v;
  endfunction

  logic [DW-1:0] raw [NL];
  logic [DW-1:0] cut [NL];

  assign raw[0] = swap ? s_bus : y_bus;
  assign raw[1] = c_bus;
  assign raw[2] = swap ? y_bus : s_bus;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign cut[g] = trim(raw[g], narrow);
  end

  assign lane_y = cut[0];
  assign lane_c = cut[1];
  assign lane_s = cut[2];
endmodule

// File: rtl/ycc_word_src.sv
module ycc_word_src #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ddr_en,
  input  logic          in_valid,
  input  logic          edge_rise,
  input  logic          y_on_rise,
  input  logic [DW-1:0] lane_y,
  input  logic [DW-1:0] lane_c,
  output logic          word_v,
  output logic [DW-1:0] word_y,
  output logic [DW-1:0] word_c
);
  logic [DW-1:0] rise_samp;

  always_ff @(posedge clk) begin
    if (!rst_n) rise_samp <= '0;
    else if (ddr_en && in_valid && edge_rise) rise_samp <= lane_y;
  end

  always_comb begin
    if (ddr_en) begin
      word_v = in_valid & ~edge_rise;
      word_y = y_on_rise ? rise_samp : lane_y;
      word_c = y_on_rise ? lane_y : rise_samp;
    end else begin
      word_v = in_valid;
      word_y = lane_y;
      word_c = lane_c;
    end
  end
endmodule

// File: rtl/ycc_chroma_pair.sv
module ycc_chroma_pair #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          line_start,
  input  logic          cr_first,
  input  logic          word_v,
  input  logic [DW-1:0] word_y,
  input  logic [DW-1:0] word_c,
  output logic          emit0,
  output logic [DW-1:0] px0_y,
  output logic [DW-1:0] px0_cb,
  output logic [DW-1:0] px0_cr,
  output logic          emit1,
  output logic [DW-1:0] px1_y,
  output logic [DW-1:0] px1_cb,
  output logic [DW-1:0] px1_cr
);
  // returns {cb, cr} from the chroma samples in arrival order
  function automatic logic [2*DW-1:0] order_chroma(input logic [DW-1:0] first,
                                                   input logic [DW-1:0] second,
                                                   input logic crf);
    return crf ? {second, first} : {first, second};
  endfunction

  logic          phase;
  logic          pend;
  logic          ph_eff;
  logic [DW-1:0] y_hold, c_hold, y_pend, cb_pend, cr_pend;

  assign ph_eff = line_start ? 1'b0 : phase;
  assign emit0  = en & word_v & ph_eff;
  assign px0_y  = y_hold;
  assign {px0_cb, px0_cr} = order_chroma(c_hold, word_c, cr_first);
  assign emit1  = pend;
  assign px1_y  = y_pend;
  assign px1_cb = cb_pend;
  assign px1_cr = cr_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      pend    <= 1'b0;
      y_hold  <= '0;
      c_hold  <= '0;
      y_pend  <= '0;
      cb_pend <= '0;
      cr_pend <= '0;
    end else if (!en) begin
      phase <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pend <= emit0;
      if (emit0) begin
        y_pend  <= word_y;
        cb_pend <= px0_cb;
        cr_pend <= px0_cr;
      end
      if (word_v) begin
        phase <= ~ph_eff;
        if (!ph_eff) begin
          y_hold <= word_y;
          c_hold <= word_c;
        end
      end else if (line_start) begin
        phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ycc_demux.sv
module ycc_demux
  import ycc_pkg::*;
#(
  parameter int DW   = 10,
  parameter int DROP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          hsync_n,
  input  logic          edge_rise,
  input  logic [DW-1:0] y_bus,
  input  logic [DW-1:0] c_bus,
  input  logic [DW-1:0] s_bus,
  input  logic          cfg_fmt422,
  input  logic          cfg_ddr,
  input  logic          cfg_cr_first,
  input  logic          cfg_swap,
  input  logic          cfg_narrow,
  input  logic          cfg_y_on_rise,
  output logic          out_valid,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cb,
  output logic [DW-1:0] out_cr
);
  ycc_mode_e     mode;
  logic          is_444;
  logic          hs_q;
  logic          line_start;
  logic [DW-1:0] lane_y, lane_c, lane_s;
  logic          word_v;
  logic [DW-1:0] word_y, word_c;
  logic          emit0, emit1;
  logic [DW-1:0] px0_y, px0_cb, px0_cr, px1_y, px1_cb, px1_cr;
  logic          nxt_v;
  logic [DW-1:0] nxt_y, nxt_cb, nxt_cr;

  assign mode       = mode_of(cfg_fmt422, cfg_ddr);
  assign is_444     = (mode == MODE_444);
  assign line_start = hs_q & ~hsync_n;

  always_ff @(posedge clk) begin
    if (!rst_n) hs_q <= 1'b1;
    else        hs_q <= hsync_n;
  end

  ycc_lane_sel #(.DW(DW), .DROP(DROP)) u_lane (
    .y_bus(y_bus), .c_bus(c_bus), .s_bus(s_bus),
    .swap(cfg_swap), .narrow(cfg_narrow),
    .lane_y(lane_y), .lane_c(lane_c), .lane_s(lane_s)
  );

  ycc_word_src #(.DW(DW)) u_word (
    .clk(clk), .rst_n(rst_n), .ddr_en(mode == MODE_DDR),
    .in_valid(in_valid), .edge_rise(edge_rise), .y_on_rise(cfg_y_on_rise),
    .lane_y(lane_y), .lane_c(lane_c),
    .word_v(word_v), .word_y(word_y), .word_c(word_c)
  );

  ycc_chroma_pair #(.DW(DW)) u_pair (
    .clk(clk), .rst_n(rst_n), .en(!is_444), .line_start(line_start),
    .cr_first(cfg_cr_first), .word_v(word_v), .word_y(word_y), .word_c(word_c),
    .emit0(emit0), .px0_y(px0_y), .px0_cb(px0_cb), .px0_cr(px0_cr),
    .emit1(emit1), .px1_y(px1_y), .px1_cb(px1_cb), .px1_cr(px1_cr)
  );

  always_comb begin
    nxt_v  = 1'b0;
    nxt_y  = px1_y;
    nxt_cb = px1_cb;
    nxt_cr = px1_cr;
    if (is_444) begin
      nxt_v  = in_valid;
      nxt_y  = lane_y;
      nxt_cb = lane_c;
      nxt_cr = lane_s;
    end else if (emit0) begin
      nxt_v  = 1'b1;
      nxt_y  = px0_y;
      nxt_cb = px0_cb;
      nxt_cr = px0_cr;
    end else if (emit1) begin
      nxt_v  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_cb    <= '0;
      out_cr    <= '0;
    end else begin
      out_valid <= nxt_v;
      if (nxt_v) begin
        out_y  <= nxt_y;
        out_cb <= nxt_cb;
        out_cr <= nxt_cr;
      end
    end
  end
endmodule

// File: rtl/ycc_demux_chk.sv
module ycc_demux_chk #(
  parameter int DW   = 10,
  parameter int DROP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          is_444,
  input logic          cfg_narrow,
  input logic          line_start,
  input logic          emit0,
  input logic          emit1,
  input logic          out_valid,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_cb,
  input logic [DW-1:0] out_cr
);
  localparam logic [DW-1:0] LOW_MASK = DW'((1 << DROP) - 1);

  AST_FULL_RATE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_444 && in_valid) |=> out_valid); // R1

  AST_NARROW_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_narrow && out_valid) |-> (((out_y | out_cb | out_cr) & LOW_MASK) == '0)); // R3

  AST_PAIR_SAME_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
    emit0 |-> ##2 (out_valid && $stable(out_cb) && $stable(out_cr))); // R4

  AST_NO_DOUBLE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(emit0 && emit1)); // R4

  AST_LINE_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> !emit0); // R6

  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) || $past(out_valid))); // R8
endmodule

bind ycc_demux ycc_demux_chk #(.DW(DW), .DROP(DROP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_444(is_444),
  .cfg_narrow(cfg_narrow), .line_start(line_start), .emit0(emit0), .emit1(emit1),
  .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
);

// File: tb/sim_ycc_demux.sv
module sim_ycc_demux;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, hsync_n = 1'b1, edge_rise = 1'b0;
  logic [DW-1:0] y_bus = '0, c_bus = '0, s_bus = '0;
  logic cfg_fmt422 = 0, cfg_ddr = 0, cfg_cr_first = 0, cfg_swap = 0, cfg_narrow = 0, cfg_y_on_rise = 0;
  logic out_valid;
  logic [DW-1:0] out_y, out_cb, out_cr;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string tag = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  ycc_demux #(.DW(DW), .DROP(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hsync_n(hsync_n), .edge_rise(edge_rise),
    .y_bus(y_bus), .c_bus(c_bus), .s_bus(s_bus),
    .cfg_fmt422(cfg_fmt422), .cfg_ddr(cfg_ddr), .cfg_cr_first(cfg_cr_first),
    .cfg_swap(cfg_swap), .cfg_narrow(cfg_narrow), .cfg_y_on_rise(cfg_y_on_rise),
    .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  // ---------------- behavioural reference ----------------
  typedef struct { int due; int y; int cb; int cr; } pix_t;
  pix_t exp_q[$];
  bit prev_hs = 1;
  int have_first = 0;
  int first_y = 0, first_c = 0, rise_val = 0;

  function automatic int fit(input int v);
    return cfg_narrow ? (v / 4) * 4 : v;
  endfunction

  function automatic pix_t mk(input int due, input int y, input int cb, input int cr);
    pix_t p; p.due = due; p.y = y; p.cb = cb; p.cr = cr; return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete(); prev_hs = 1; have_first = 0; rise_val = 0;
    end else begin
      int vy, vc, vs, wy, wc, cb, cr;
      bit fall, got;
      cyc++;
      vy = fit(cfg_swap ? int'(s_bus) : int'(y_bus));
      vc = fit(int'(c_bus));
      vs = fit(cfg_swap ? int'(y_bus) : int'(s_bus));
      fall = prev_hs && !hsync_n;
      prev_hs = hsync_n;
      got = 0; wy = 0; wc = 0;
      if (!cfg_fmt422 && !cfg_ddr) begin
        if (in_valid) exp_q.push_back(mk(cyc, vy, vc, vs));
      end else begin
        if (cfg_ddr) begin
          if (in_valid && edge_rise) rise_val = vy;
          else if (in_valid) begin
            got = 1;
            wy = cfg_y_on_rise ? rise_val : vy;
            wc = cfg_y_on_rise ? vy : rise_val;
          end
        end else if (in_valid) begin
          got = 1; wy = vy; wc = vc;
        end
        if (fall) have_first = 0;
        if (got) begin
          if (have_first == 0) begin
            first_y = wy; first_c = wc; have_first = 1;
          end else begin
            cb = cfg_cr_first ? wc : first_c;
            cr = cfg_cr_first ? first_c : wc;
            exp_q.push_back(mk(cyc, first_y, cb, cr));
            exp_q.push_back(mk(cyc + 1, wy, cb, cr));
            have_first = 0;
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic compare();
    checks++;
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      pix_t e = exp_q.pop_front();
      if (!(out_valid && int'(out_y) == e.y && int'(out_cb) == e.cb && int'(out_cr) == e.cr)) begin
        failures++;
        $display("FAIL %s cyc=%0d actual v=%0b y=%0d cb=%0d cr=%0d expected v=1 y=%0d cb=%0d cr=%0d",
                 tag, cyc, out_valid, out_y, out_cb, out_cr, e.y, e.cb, e.cr);
      end
    end else if (out_valid) begin
      failures++;
      $display("FAIL %s cyc=%0d actual v=1 expected v=0 (R8/R9)", tag, cyc);
    end
  endtask

  task automatic do_reset(input bit f422, input bit ddr, input bit crf, input bit sw,
                          input bit nar, input bit yr);
    @(negedge clk);
    rst_n = 0; in_valid = 0; hsync_n = 1; edge_rise = 0;
    cfg_fmt422 = f422; cfg_ddr = ddr; cfg_cr_first = crf;
    cfg_swap = sw; cfg_narrow = nar; cfg_y_on_rise = yr;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(input string t, input int n, input int line_len, input int pct);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      in_valid  = cfg_ddr ? 1'b1 : (($urandom % 100) < pct);
      edge_rise = cfg_ddr ? (i % 2 == 0) : 1'b0;
      y_bus     = DW'($urandom);
      c_bus     = DW'($urandom);
      s_bus     = DW'($urandom);
      hsync_n   = ((i % line_len) < 2) ? 1'b0 : 1'b1;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare();
      in_valid = 0;
    end
  endtask

  initial begin
    do_reset(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_y !== '0 || out_cb !== '0 || out_cr !== '0) begin
      failures++;
      $display("FAIL R8 reset actual v=%0b y=%0d cb=%0d cr=%0d expected all 0",
               out_valid, out_y, out_cb, out_cr);
    end
    run("R1/R9 full-rate", 300, 40, 70);
    do_reset(0, 0, 0, 1, 0, 0);
    run("R2 full-rate swap", 200, 40, 80);
    do_reset(0, 0, 0, 0, 1, 0);
    run("R3 full-rate narrow", 200, 40, 80);
    do_reset(1, 0, 0, 0, 0, 0);
    run("R4/R5/R9 half-rate cb-first", 400, 30, 60);
    do_reset(1, 0, 1, 1, 0, 0);
    run("R5/R2 half-rate cr-first swap", 300, 30, 75);
    do_reset(1, 0, 0, 0, 0, 0);
    run("R6 half-rate odd lines", 400, 17, 100);
    do_reset(1, 1, 0, 0, 0, 0);
    run("R7 ddr chroma on rise", 400, 23, 100);
    do_reset(1, 1, 1, 1, 1, 1);
    run("R7/R3 ddr luma on rise narrow", 400, 21, 100);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule